// File: doc/BRIEF.md
# ADC Result Holding and Overrun Tracking

This block holds converter results for a bus-readable register interface. When the converter reports a finished conversion, the block records the result and the channel it belongs to. The result is kept in a register for that channel and in a shared "most recent result" register. For each channel the block keeps a result-pending flag and a lost-result flag. For the block as a whole it keeps a global pending flag and a global lost-result flag. Read strobes from the bus decoder clear these flags. Reading a channel's data clears that channel's pending flag. Reading the shared register clears the global pending flag. Reading the status word clears every lost-result flag.

The block also makes the conversion start pulse. Software can request a start directly. Otherwise a hardware source can start a conversion: one of several timer outputs or an external pin. A select field picks the source, and an enable bit gates it. Each rising edge of the chosen source gives exactly one start pulse. The external pin is synchronized with two flip-flops first. The analog converter, the channel sequencing and the bus protocol are handled outside this block.

Top module: `adc_result_flags`

## Requirements
- R1: After reset the status word, the shared result, every channel result and `start_pulse` are all zero.
- R2: A `conv_done` cycle writes `conv_data` into the channel register chosen by `conv_ch` and into `last_data`. It also sets that channel's pending bit and the global pending bit. All of these are visible in the next cycle.
- R3: A `rd_ch_data` strobe clears the pending bit of channel `rd_ch_sel` only. While `rd_ch_data` is high, `ch_rdata` shows that channel's stored result.
- R4: A `rd_last` strobe clears the global pending bit.
- R5: A result for a channel whose pending bit is still set sets that channel's lost-result bit.
- R6: Any result that arrives while the global pending bit is set sets the global lost-result bit.
- R7: A `rd_status` strobe clears all per-channel lost-result bits and the global lost-result bit. It leaves the pending bits unchanged.
- R8: If a flag is set and cleared in the same cycle, the set wins. This covers a pending bit against its read and a lost-result bit against a status read.
- R9: The status word packs its fields as follows. Channel pending bits are in bits 0 to 7, with channel n at bit n. Channel lost-result bits are in bits 8 to 15, with channel n at bit 8+n. The global pending bit is bit 16 and the global lost-result bit is bit 17.
- R10: `sw_start` high for one cycle gives exactly one `start_pulse` in the next cycle, whatever `trg_en` is.
- R11: `trg_sel` values 0 to 2 pick `timer_trg[0..2]` and value 3 picks `ext_trg`. Rising edges of the picked source produce start pulses only while `trg_en` is 1. Sources that are not selected never produce a pulse.
- R12: Each rising edge of the selected hardware source gives exactly one `start_pulse`, however long the source then stays high. An `ext_trg` edge reaches `start_pulse` after two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle conversion-finished strobe |
| conv_ch | input | 3 | Channel of the finished conversion |
| conv_data | input | 10 | Result of the finished conversion |
| rd_status | input | 1 | Status word read strobe |
| rd_ch_data | input | 1 | Channel result read strobe |
| rd_ch_sel | input | 3 | Channel addressed by the result read |
| rd_last | input | 1 | Shared result read strobe |
| sw_start | input | 1 | Software start request |
| trg_en | input | 1 | Hardware trigger enable |
| trg_sel | input | 2 | Hardware trigger source select |
| timer_trg | input | 3 | Timer trigger outputs |
| ext_trg | input | 1 | Asynchronous external trigger pin |
| status | output | 18 | Packed flag word |
| ch_rdata | output | 10 | Stored result of channel `rd_ch_sel` |
| last_data | output | 10 | Most recent result of any channel |
| start_pulse | output | 1 | One-cycle conversion start |

## Verification
The hardest case to reach is a set and a clear of the same flag in one cycle. This needs a new result for a channel whose pending bit is already set. In the same cycle there must also be a read of that channel, a read of the status word and a read of the shared register. The stimulus first sets up pending state on two channels. It then drives all four strobes in a single cycle. The result is checked against a status word where every set has won: pending held, lost-result newly set, global lost-result set.

// File: rtl/adc_result_flags.sv
module adc_result_flags #(
  parameter int NCH  = 8,
  parameter int DW   = 10,
  parameter int NTMR = 3,
  localparam int CHW = $clog2(NCH),
  localparam int TSW = $clog2(NTMR + 1),
  localparam int SW  = 2 * NCH + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv_done,
  input  logic [CHW-1:0] conv_ch,
  input  logic [DW-1:0]  conv_data,
  input  logic           rd_status,
  input  logic           rd_ch_data,
  input  logic [CHW-1:0] rd_ch_sel,
  input  logic           rd_last,
  input  logic           sw_start,
  input  logic           trg_en,
  input  logic [TSW-1:0] trg_sel,
  input  logic [NTMR-1:0] timer_trg,
  input  logic           ext_trg,
  output logic [SW-1:0]  status,
  output logic [DW-1:0]  ch_rdata,
  output logic [DW-1:0]  last_data,
  output logic           start_pulse
);

  logic [DW-1:0]  ch_data [NCH];
  logic [NCH-1:0] eoc, ovr;
  logic           drdy, govre;

  wire [NCH-1:0] one     = {{(NCH-1){1'b0}}, 1'b1};
  wire [NCH-1:0] wr_hit  = conv_done  ? (one << conv_ch)   : '0;
  wire [NCH-1:0] rd_hit  = rd_ch_data ? (one << rd_ch_sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc   <= '0;
      ovr   <= '0;
      drdy  <= 1'b0;
      govre <= 1'b0;
      last_data <= '0;
    end else begin
      eoc   <= wr_hit | (eoc & ~rd_hit);
      ovr   <= (wr_hit & eoc) | (ovr & ~{NCH{rd_status}});
      drdy  <= conv_done | (drdy & ~rd_last);
      govre <= (conv_done & drdy) | (govre & ~rd_status);
      if (conv_done) last_data <= conv_data;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ch_data[i] <= '0;
      else if (wr_hit[i]) ch_data[i] <= conv_data;
    end
  end

  assign ch_rdata = ch_data[rd_ch_sel];
  assign status   = {govre, drdy, ovr, eoc};

  logic [1:0]      ext_sync;
  logic            ext_prev;
  logic [NTMR-1:0] tmr_prev;

  wire [NTMR:0] hw_now  = {ext_sync[1], timer_trg};
  wire [NTMR:0] hw_last = {ext_prev, tmr_prev};
  wire          hw_edge = hw_now[trg_sel] & ~hw_last[trg_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync    <= '0;
      ext_prev    <= 1'b0;
      tmr_prev    <= '0;
      start_pulse <= 1'b0;
    end else begin
      ext_sync    <= {ext_sync[0], ext_trg};
      ext_prev    <= ext_sync[1];
      tmr_prev    <= timer_trg;
      start_pulse <= sw_start | (trg_en & hw_edge);
    end
  end

endmodule

module adc_result_flags_chk #(
  parameter int NCH  = 8,
  parameter int DW   = 10,
  parameter int NTMR = 3,
  localparam int CHW = $clog2(NCH),
  localparam int TSW = $clog2(NTMR + 1),
  localparam int SW  = 2 * NCH + 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           conv_done,
  input logic [CHW-1:0] conv_ch,
  input logic [DW-1:0]  conv_data,
  input logic           rd_status,
  input logic           rd_ch_data,
  input logic [CHW-1:0] rd_ch_sel,
  input logic           rd_last,
  input logic           sw_start,
  input logic           trg_en,
  input logic [TSW-1:0] trg_sel,
  input logic [NTMR-1:0] timer_trg,
  input logic           ext_trg,
  input logic [SW-1:0]  status,
  input logic [DW-1:0]  ch_rdata,
  input logic [DW-1:0]  last_data,
  input logic           start_pulse
);

  // R2
  result_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> status[2*NCH] && status[$past(conv_ch)] && last_data == $past(conv_data));

  // R4
  drdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last && !conv_done |=> !status[2*NCH]);

  // R5
  chan_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && status[conv_ch] |=> status[NCH + $past(conv_ch)]);

  // R6
  global_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && status[2*NCH] |=> status[2*NCH+1]);

  // R7
  status_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !conv_done |=> status[2*NCH+1] == 1'b0 && status[2*NCH-1:NCH] == '0);

  // R10
  sw_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start |=> start_pulse);

  // R11
  trigger_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trg_en && !sw_start |=> !start_pulse);

endmodule

bind adc_result_flags adc_result_flags_chk #(.NCH(NCH), .DW(DW), .NTMR(NTMR)) u_chk (.*);

// File: tb/adc_result_flags_bench.sv
module adc_result_flags_bench;
  logic clk = 0, rst_n = 0;
  logic conv_done = 0, rd_status = 0, rd_ch_data = 0, rd_last = 0;
  logic [2:0] conv_ch = 0, rd_ch_sel = 0;
  logic [9:0] conv_data = 0;
  logic sw_start = 0, trg_en = 0, ext_trg = 0;
  logic [1:0] trg_sel = 0;
  logic [2:0] timer_trg = 0;
  logic [17:0] status;
  logic [9:0] ch_rdata, last_data;
  logic start_pulse;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  adc_result_flags u_adc_result_flags (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic done, input logic [2:0] ch, input logic [9:0] d,
                      input logic rs, input logic rc, input logic [2:0] sel, input logic rl);
    @(negedge clk);
    conv_done = done; conv_ch = ch; conv_data = d;
    rd_status = rs; rd_ch_data = rc; rd_ch_sel = sel; rd_last = rl;
    @(negedge clk);
    conv_done = 0; rd_status = 0; rd_ch_data = 0; rd_last = 0;
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c += int'(start_pulse);
    end
  endtask

  task automatic t_reset;
    check("R1 status", 32'(status), 0);
    check("R1 last", 32'(last_data), 0);
    check("R1 start", 32'(start_pulse), 0);
    rd_ch_sel = 3;
    #1 check("R1 chdata", 32'(ch_rdata), 0);
  endtask

  task automatic t_basic;
    step(1, 3, 10'h155, 0, 0, 0, 0);
    check("R2 R9 status", 32'(status), 32'h10008);
    check("R2 last", 32'(last_data), 32'h155);
    step(1, 5, 10'h2AA, 0, 0, 0, 0);
    check("R6 R9 status", 32'(status), 32'h30028);
    check("R2 last2", 32'(last_data), 32'h2AA);
  endtask

  task automatic t_clear;
    @(negedge clk);
    rd_ch_sel = 3; rd_ch_data = 1;
    #1 check("R3 chdata", 32'(ch_rdata), 32'h155);
    @(negedge clk);
    rd_ch_data = 0;
    check("R3 status", 32'(status), 32'h30020);
    step(0, 0, 0, 0, 0, 0, 1);
    check("R4 status", 32'(status), 32'h20020);
    step(0, 0, 0, 1, 0, 0, 0);
    check("R7 status", 32'(status), 32'h00020);
  endtask

  task automatic t_overrun;
    step(1, 5, 10'h011, 0, 0, 0, 0);
    check("R5 status", 32'(status), 32'h12020);
    step(1, 1, 10'h3FF, 0, 0, 0, 0);
    check("R6 status", 32'(status), 32'h32022);
    rd_ch_sel = 5;
    #1 check("R2 ch5 data", 32'(ch_rdata), 32'h011);
    step(0, 0, 0, 1, 0, 0, 0);
    check("R7 keep pending", 32'(status), 32'h10022);
  endtask

  task automatic t_collision;
    step(1, 5, 10'h0A5, 1, 1, 5, 1);
    check("R8 set wins", 32'(status), 32'h32022);
    check("R8 last", 32'(last_data), 32'h0A5);
  endtask

  task automatic t_sw;
    int c, c2;
    trg_en = 0;
    @(negedge clk); sw_start = 1;
    @(negedge clk); sw_start = 0;
    c = int'(start_pulse);
    count_pulses(3, c2);
    check("R10 next cycle", 32'(c), 1);
    check("R10 one pulse", 32'(c2), 0);
  endtask

  task automatic t_hw;
    int c;
    trg_sel = 1; trg_en = 1;
    @(negedge clk); timer_trg[1] = 1;
    count_pulses(6, c);
    check("R11 R12 timer1", 32'(c), 1);
    timer_trg[1] = 0;
    @(negedge clk); timer_trg[0] = 1;
    count_pulses(4, c);
    check("R11 unselected", 32'(c), 0);
    timer_trg[0] = 0;
    trg_sel = 3;
    @(negedge clk); ext_trg = 1;
    count_pulses(10, c);
    check("R12 ext one pulse", 32'(c), 1);
    ext_trg = 0;
    count_pulses(4, c);
    trg_en = 0;
    @(negedge clk); ext_trg = 1;
    count_pulses(8, c);
    check("R11 disabled", 32'(c), 0);
    ext_trg = 0;
    count_pulses(4, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_clear();
    t_overrun();
    t_collision();
    t_sw();
    t_hw();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule